// File: doc/BRIEF.md
# Codec Control Port Initializer

This block brings an audio codec out of reset and configures it over a three-wire serial control port. The port has an active-low select, a control clock and one data line. The block also drives the codec's active-low reset pin. Leaving system reset, the block holds the codec in reset, with select low, for a programmable number of system clocks. It then releases the codec reset and shifts out a throw-away frame, which the codec discards. After a short pause with select high, it shifts out the real configuration frame.

Each frame is 32 bits long and is sent most significant bit first in one select window. The frame is assembled from parallel setting inputs: two 5-bit playback attenuations, a mute, two capture source selects, two 4-bit capture gains, an interrupt mask and a general-purpose output bit. After the first configuration, a start pulse sends one new frame with the current settings and no throw-away frame. A done flag reports that the latest frame is complete. The block never reads status back from the codec.

Top module: `codec_ctl_init`

## Requirements
- R1: While rst_n is low, and for RST_HOLD_CYC system clocks after it rises, codec_rst_n_o and cs_n_o are low, cclk_o is low, done_o is low and busy_o is high. Asserting rst_n at any time returns the block to this state.
- R2: When the hold time ends, codec_rst_n_o rises and the throw-away frame starts with cs_n_o still low. That frame carries the same word as the real frame.
- R3: A frame is 32 cclk_o pulses with cs_n_o low throughout. The bits go out most significant bit first. cdata_o changes only together with a rising cclk_o and is stable at each falling cclk_o, where the codec samples it. cclk_o rests low.
- R4: Frame layout. Bit 31 is 0. Bit 30 is irq_mask_i and bit 29 is aux_out_i. Bits 28:24 are atten_l_i and bits 23:19 are atten_r_i. Bit 18 is mute_i. Bit 17 is src_l_i and bit 16 is src_r_i. Bits 15:12 are gain_l_i and bits 11:8 are gain_r_i. Bits 7:0 are 0.
- R5: Between the throw-away frame and the real frame, cs_n_o is high for exactly 2*CCLK_HALF_CYC system clocks.
- R6: Each power-up sequence sends exactly two frames and then goes idle.
- R7: done_o rises on the same clock edge on which cs_n_o rises at the end of a real frame. At that point busy_o falls. done_o then stays high until the next accepted start.
- R8: Each high phase and each low phase of cclk_o lasts CCLK_HALF_CYC system clocks.
- R9: A start_i high while idle sends exactly one frame one clock later, with no throw-away frame and no codec reset. While that frame runs, done_o is low and busy_o is high.
- R10: start_i is ignored while busy_o is high. This includes the clock edge on which a frame completes.
- R11: The setting inputs are captured at the start of each frame. Changes during a frame do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to send one configuration frame |
| irq_mask_i | input | 1 | Codec interrupt mask setting |
| aux_out_i | input | 1 | Codec general-purpose output bit |
| atten_l_i | input | 5 | Left playback attenuation, 1.5 dB per step |
| atten_r_i | input | 5 | Right playback attenuation, 1.5 dB per step |
| mute_i | input | 1 | Playback mute |
| src_l_i | input | 1 | Left capture source select |
| src_r_i | input | 1 | Right capture source select |
| gain_l_i | input | 4 | Left capture gain, 1.5 dB per step |
| gain_r_i | input | 4 | Right capture gain, 1.5 dB per step |
| codec_rst_n_o | output | 1 | Active-low codec reset |
| cs_n_o | output | 1 | Active-low control port select |
| cclk_o | output | 1 | Control port clock |
| cdata_o | output | 1 | Control port serial data |
| busy_o | output | 1 | A sequence or frame is in progress |
| done_o | output | 1 | The latest real frame has completed |

## Verification
Two events can land on the same clock edge: the completion of a frame and a new start request. The bench watches the final falling cclk_o and counts CCLK_HALF_CYC clocks from it. It then holds start_i high for only the completion edge. The result passes if done_o rises, busy_o stays low and no further select window opens. A later start one clock after completion must be accepted. A second overlap also needs to be ignored: settings changed together with a start request in the middle of a frame. The bench checks that the frame in flight still carries the settings captured at its start.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  typedef enum logic [1:0] {
    ST_HOLD,
    ST_FRAME,
    ST_GAP,
    ST_IDLE
  } seq_state_t;

  // Field order matches the on-wire order below bit 31.
  typedef struct packed {
    logic       irq_mask;
    logic       aux_out;
    logic [4:0] atten_l;
    logic [4:0] atten_r;
    logic       mute;
    logic       src_l;
    logic       src_r;
    logic [3:0] gain_l;
    logic [3:0] gain_r;
  } codec_cfg_t;

  localparam int unsigned CFG_W = $bits(codec_cfg_t);

endpackage

// File: rtl/codec_frame_pack.sv
module codec_frame_pack
  import codec_ctl_pkg::*;
#(
  parameter int unsigned FRAME_W = 32
) (
  input  codec_cfg_t           cfg_i,
  output logic [FRAME_W-1:0]   word_o
);

  localparam int unsigned PAD_W = FRAME_W - 1 - CFG_W;

  // Leading zero bit, settings, zero padding down to bit 0.
  assign word_o = {1'b0, cfg_i, {PAD_W{1'b0}}};

endmodule

// File: rtl/codec_ctl_timer.sv
module codec_ctl_timer #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/codec_ctl_shifter.sv
module codec_ctl_shifter #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               msb_o,
  output logic               last_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load_i) begin
      sh_d  = word_i;
      idx_d = '0;
    end else if (shift_i) begin
      sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign msb_o  = sh_q[FRAME_W-1];
  assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/codec_ctl_init.sv
module codec_ctl_init
  import codec_ctl_pkg::*;
#(
  parameter int unsigned RST_HOLD_CYC  = 10_000_000,
  parameter int unsigned CCLK_HALF_CYC = 16,
  parameter int unsigned FRAME_W       = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       irq_mask_i,
  input  logic       aux_out_i,
  input  logic [4:0] atten_l_i,
  input  logic [4:0] atten_r_i,
  input  logic       mute_i,
  input  logic       src_l_i,
  input  logic       src_r_i,
  input  logic [3:0] gain_l_i,
  input  logic [3:0] gain_r_i,
  output logic       codec_rst_n_o,
  output logic       cs_n_o,
  output logic       cclk_o,
  output logic       cdata_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int unsigned GAP_CYC = 2 * CCLK_HALF_CYC;
  localparam int unsigned TMR_MAX = (RST_HOLD_CYC > GAP_CYC) ? RST_HOLD_CYC : GAP_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] HOLD_LD = TMR_W'(RST_HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(CCLK_HALF_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(GAP_CYC - 1);

  seq_state_t state_q, state_d;
  logic       phase_hi_q, phase_hi_d;
  logic       dummy_q, dummy_d;
  logic       done_q, done_d;

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_msb, sh_last;

  codec_cfg_t         cfg;
  logic [FRAME_W-1:0] frame_word;

  assign cfg = '{irq_mask: irq_mask_i, aux_out: aux_out_i,
                 atten_l: atten_l_i, atten_r: atten_r_i,
                 mute: mute_i, src_l: src_l_i, src_r: src_r_i,
                 gain_l: gain_l_i, gain_r: gain_r_i};

  codec_frame_pack #(.FRAME_W(FRAME_W)) pack_i (
    .cfg_i  (cfg),
    .word_o (frame_word)
  );

  codec_ctl_timer #(.W(TMR_W), .RST_VAL(HOLD_LD)) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  codec_ctl_shifter #(.FRAME_W(FRAME_W)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .word_i  (frame_word),
    .msb_o   (sh_msb),
    .last_o  (sh_last)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    phase_hi_d = phase_hi_q;
    dummy_d    = dummy_q;
    done_d     = done_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        if (tmr_zero) begin
          state_d    = ST_FRAME;
          dummy_d    = 1'b1;
          phase_hi_d = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = HALF_LD;
          sh_load    = 1'b1;
        end
      end
      ST_FRAME: begin
        if (tmr_zero) begin
          if (phase_hi_q) begin
            phase_hi_d = 1'b0;
            tmr_load   = 1'b1;
            tmr_val    = HALF_LD;
          end else if (sh_last) begin
            if (dummy_q) begin
              state_d  = ST_GAP;
              tmr_load = 1'b1;
              tmr_val  = GAP_LD;
            end else begin
              state_d  = ST_IDLE;
              done_d   = 1'b1;
            end
          end else begin
            sh_shift   = 1'b1;
            phase_hi_d = 1'b1;
            tmr_load   = 1'b1;
            tmr_val    = HALF_LD;
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          state_d    = ST_FRAME;
          dummy_d    = 1'b0;
          phase_hi_d = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = HALF_LD;
          sh_load    = 1'b1;
        end
      end
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_FRAME;
          dummy_d    = 1'b0;
          done_d     = 1'b0;
          phase_hi_d = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = HALF_LD;
          sh_load    = 1'b1;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HOLD;
      phase_hi_q <= 1'b0;
      dummy_q    <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      phase_hi_q <= phase_hi_d;
      dummy_q    <= dummy_d;
      done_q     <= done_d;
    end
  end

  assign codec_rst_n_o = (state_q != ST_HOLD);
  assign cs_n_o        = (state_q == ST_GAP) || (state_q == ST_IDLE);
  assign cclk_o        = (state_q == ST_FRAME) && phase_hi_q;
  assign cdata_o       = sh_msb;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;

endmodule

// File: rtl/codec_ctl_init_chk.sv
module codec_ctl_init_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic codec_rst_n_o,
  input logic cs_n_o,
  input logic cclk_o,
  input logic cdata_o,
  input logic busy_o,
  input logic done_o
);

  AST_CLK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |-> !cs_n_o) else $error("cclk outside select window"); // R3

  AST_DATA_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_o) |-> $stable(cdata_o)) else $error("data moved at sample edge"); // R3

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n_o |-> (!cs_n_o && !cclk_o && busy_o)) else $error("activity during hold"); // R1

  AST_DONE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $rose(cs_n_o)) else $error("done not aligned to select release"); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o) else $error("done while busy"); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o) else $error("left idle without start"); // R9

  AST_NO_CODEC_RERESET: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_n_o |=> codec_rst_n_o) else $error("codec reset re-asserted"); // R9

endmodule

bind codec_ctl_init codec_ctl_init_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .codec_rst_n_o (codec_rst_n_o),
  .cs_n_o        (cs_n_o),
  .cclk_o        (cclk_o),
  .cdata_o       (cdata_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/codec_ctl_init_tb_top.sv
`timescale 1ns/1ps
module codec_ctl_init_tb_top;

  localparam int unsigned HOLD = 40;
  localparam int unsigned HALF = 3;
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    23'h1F3C5A, 23'h7FFFFF, 23'h000000, 23'h555555, 23'h2AAAAA, 23'h400001
  };

  logic clk = 1'b0;
  logic rst_n, start_i;
  logic irq_mask_i, aux_out_i, mute_i, src_l_i, src_r_i;
  logic [4:0] atten_l_i, atten_r_i;
  logic [3:0] gain_l_i, gain_r_i;
  logic codec_rst_n_o, cs_n_o, cclk_o, cdata_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  codec_ctl_init #(.RST_HOLD_CYC(HOLD), .CCLK_HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .irq_mask_i(irq_mask_i), .aux_out_i(aux_out_i),
    .atten_l_i(atten_l_i), .atten_r_i(atten_r_i), .mute_i(mute_i),
    .src_l_i(src_l_i), .src_r_i(src_r_i),
    .gain_l_i(gain_l_i), .gain_r_i(gain_r_i),
    .codec_rst_n_o(codec_rst_n_o), .cs_n_o(cs_n_o), .cclk_o(cclk_o),
    .cdata_o(cdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Port monitors
  logic [31:0] mon_word = '0;
  int mon_bits = 0;
  int start_bits = 0;
  logic [31:0] last_word = '0, prev_word = '0;
  int last_bits = 0;
  int frame_cnt = 0;
  int gap_cnt = 0;
  int hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0;

  always @(negedge cclk_o) begin
    mon_word = {mon_word[30:0], cdata_o};
    mon_bits = mon_bits + 1;
  end
  always @(negedge cs_n_o) start_bits = mon_bits;
  always @(posedge cs_n_o) begin
    prev_word = last_word;
    last_word = mon_word;
    last_bits = mon_bits - start_bits;
    frame_cnt = frame_cnt + 1;
  end
  always @(negedge clk) begin
    if (rst_n && cs_n_o && busy_o) gap_cnt = gap_cnt + 1;
    if (cclk_o) begin
      hi_run = hi_run + 1;
      if (lo_run != 0) last_lo = lo_run;
      lo_run = 0;
    end else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
      if (rst_n && !cs_n_o && codec_rst_n_o) lo_run = lo_run + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [22:0] v);
    {irq_mask_i, aux_out_i, atten_l_i, atten_r_i, mute_i, src_l_i, src_r_i,
     gain_l_i, gain_r_i} = v;
  endtask

  function automatic logic [31:0] exp_word(input logic [22:0] v);
    return {1'b0, v, 8'h00};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int fc, g0, lo;
    rst_n = 1'b0; start_i = 1'b0;
    set_cfg(VEC[0]);
    repeat (3) @(negedge clk);
    chk(!codec_rst_n_o && !cs_n_o && !cclk_o, "R1 reset pins", {codec_rst_n_o, cs_n_o, cclk_o}, 0);
    chk(!done_o && busy_o, "R1 reset flags", {done_o, busy_o}, 1);
    rst_n = 1'b1;
    lo = 0;
    @(negedge clk);
    while (!codec_rst_n_o) begin lo++; @(negedge clk); end
    chk(lo == HOLD - 1, "R1 hold length", lo, HOLD - 1);
    chk(!cs_n_o && frame_cnt == 0, "R2 select still low at release", cs_n_o, 0);
    wait_done();
    chk(frame_cnt == 2, "R6 two frames at power-up", frame_cnt, 2);
    chk(prev_word == exp_word(VEC[0]), "R2 throw-away word", prev_word, exp_word(VEC[0]));
    chk(last_word == exp_word(VEC[0]), "R4 real frame word", last_word, exp_word(VEC[0]));
    chk(last_bits == 32, "R3 bits per frame", last_bits, 32);
    chk(gap_cnt == 2 * HALF, "R5 gap length", gap_cnt, 2 * HALF);
    chk(last_hi == HALF, "R8 high phase", last_hi, HALF);
    chk(last_lo == HALF, "R8 low phase", last_lo, HALF);
    repeat (10) @(negedge clk);
    chk(done_o && !busy_o && cs_n_o, "R7 done held in idle", {done_o, busy_o}, 2);

    // Table walk: one frame per start with the layout of R4
    for (int i = 0; i < NV; i++) begin
      fc = frame_cnt;
      set_cfg(VEC[i]);
      pulse_start();
      chk(busy_o && !done_o && codec_rst_n_o, "R9 start accepted", {busy_o, done_o}, 2);
      wait_done();
      chk(frame_cnt == fc + 1, "R9 single frame", frame_cnt, fc + 1);
      chk(last_word == exp_word(VEC[i]), "R4 vector word", last_word, exp_word(VEC[i]));
      chk(last_bits == 32, "R3 vector bits", last_bits, 32);
    end

    // Settings change and start request in the middle of a frame
    fc = frame_cnt;
    set_cfg(VEC[3]);
    pulse_start();
    wait ((mon_bits - start_bits) >= 10);
    @(negedge clk);
    set_cfg(VEC[4]);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    chk(last_word == exp_word(VEC[3]), "R11 captured at frame start", last_word, exp_word(VEC[3]));
    repeat (8 * HALF) @(negedge clk);
    chk(frame_cnt == fc + 1 && done_o, "R10 mid-frame start ignored", frame_cnt, fc + 1);

    // Start on the completion edge of a frame
    fc = frame_cnt;
    set_cfg(VEC[5]);
    pulse_start();
    wait ((mon_bits - start_bits) == 32);
    @(negedge clk);
    repeat (HALF - 1) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(done_o && !busy_o, "R7 completion with start", {done_o, busy_o}, 2);
    chk(last_word == exp_word(VEC[5]), "R4 completion word", last_word, exp_word(VEC[5]));
    repeat (6 * HALF) @(negedge clk);
    chk(frame_cnt == fc + 1 && !busy_o, "R10 completion-edge start ignored", frame_cnt, fc + 1);
    pulse_start();
    chk(busy_o, "R9 start right after completion", busy_o, 1);
    wait_done();

    // Reset in the middle of a frame
    set_cfg(VEC[2]);
    pulse_start();
    wait ((mon_bits - start_bits) >= 5);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!codec_rst_n_o && !cs_n_o && !cclk_o && !done_o, "R1 reset mid-frame",
        {codec_rst_n_o, cs_n_o, cclk_o, done_o}, 0);
    fc = frame_cnt;
    g0 = gap_cnt;
    @(negedge clk); rst_n = 1'b1;
    wait_done();
    chk(frame_cnt == fc + 2, "R6 two frames after re-reset", frame_cnt, fc + 2);
    chk(gap_cnt - g0 == 2 * HALF, "R5 gap after re-reset", gap_cnt - g0, 2 * HALF);
    chk(last_word == exp_word(VEC[2]), "R4 word after re-reset", last_word, exp_word(VEC[2]));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule